// File: doc/BRIEF.md
# Memory Operation Ordering Queue

This block tracks in-flight memory operations in program order and decides, every cycle, which of them may execute under a relaxed consistency model. The front end presents one operation per cycle, tagged as a load, a store, or one of three kinds of barrier. If there is room, the block places it in a slot of an age-ordered ring and returns the slot number. Execution units later report completion using that slot number. The block uses no addresses at all. Its permissions come only from operation kinds, relative age and a single no-alias mode bit, which states whether loads may be assumed not to overlap older stores.

Loads and load-side barriers draw on a load budget, and stores and store-side barriers draw on a store budget. A full barrier draws one unit from each. A barrier never executes in the usual sense. It counts as executed in the cycle it becomes the oldest slot, and it leaves the ring on the next edge. An operation that may read memory and has side effects should be sent as a load barrier. One that may write memory and has side effects should be sent as a store barrier. One that does both should be sent as a full barrier. Each cycle in which an offered operation is refused adds one to a stall count.

Top module: `mem_order_queue`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every slot is empty: `exec_ok` is all zero, both full flags are low and `stall_cnt` is zero.
- R2: `alloc_kind` codes are 0 load, 1 store, 2 load barrier, 3 store barrier and 4 full barrier. An accepted operation, flagged by `alloc_ok` in the same cycle, takes the slot shown on `alloc_idx`. Slots are handed out in ascending order from 0 and wrap after slot LQ_N+SQ_N-1.
- R3: Codes 0 and 2 use one load-budget unit, codes 1 and 3 use one store-budget unit, and code 4 uses one of each. The load budget LQ_N is LQ_SIZE, or DEF_LQ (6) when LQ_SIZE is 0. The store budget SQ_N is SQ_SIZE, or DEF_SQ (4) when SQ_SIZE is 0. `lq_full` and `sq_full` are high exactly when their budget is used up. An operation is refused when any budget it needs is used up, judged on the registered state only.
- R4: `stall_cnt` goes up by one on every edge where `alloc_valid` is high and the operation is refused. Codes 5 to 7 are always refused.
- R5: A store is permitted only when no older load or store is still pending and no older store barrier or full barrier is in the ring. This holds in either mode.
- R6: A load with an older pending store is permitted only while `no_alias` is high.
- R7: A load may run ahead of an older pending load only when no store or barrier is in the ring between the two.
- R8: A load is held while any older load barrier or full barrier is in the ring. A store is held while any older store barrier or full barrier is in the ring.
- R9: A barrier's `exec_ok` bit is high only while it is the oldest slot. That slot is freed on the next edge without any completion input.
- R10: A completion marks its slot done. The oldest slot is freed, one per edge, once it is done. Freed slots return their budget and are reused in ring order.
- R11: `exec_ok` is high only for a held load or store that has not completed, or for the oldest barrier. A completed load or store that is still held no longer blocks younger operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | An operation is offered this cycle |
| alloc_kind | input | 3 | Kind code of the offered operation |
| no_alias | input | 1 | When high, loads may run ahead of older stores |
| cmp_valid | input | 1 | A completion is reported this cycle |
| cmp_idx | input | IDX_W | Slot number of the completed operation |
| alloc_ok | output | 1 | The offered operation is accepted this cycle |
| alloc_idx | output | IDX_W | Slot that the next accepted operation takes |
| lq_full | output | 1 | Load budget used up |
| sq_full | output | 1 | Store budget used up |
| exec_ok | output | LQ_N+SQ_N | Per-slot permission to execute |
| stall_cnt | output | STALL_W | Count of refused-offer cycles |

## Verification
The assertions assume that a completion names a slot that holds a load or store that is still pending. A completion to an empty slot, to a barrier, or repeated for the same operation is outside the contract. The bench keeps to this by choosing each completion only from the slots that its own model currently permits. Those slots are by definition pending loads or stores. Alongside this, the offered kinds include a share of illegal codes, and phases alternate between no completions at all (to reach both budget limits) and heavy completion traffic with `no_alias` in each setting.

// File: rtl/ord_pkg.sv
package ord_pkg;
  typedef enum logic [2:0] {
    MK_LOAD    = 3'd0,
    MK_STORE   = 3'd1,
    MK_LDBAR   = 3'd2,
    MK_STBAR   = 3'd3,
    MK_FULLBAR = 3'd4
  } mop_kind_e;

  function automatic logic takes_lq(input mop_kind_e k);
    return (k == MK_LOAD) || (k == MK_LDBAR) || (k == MK_FULLBAR);
  endfunction

  function automatic logic takes_sq(input mop_kind_e k);
    return (k == MK_STORE) || (k == MK_STBAR) || (k == MK_FULLBAR);
  endfunction

  function automatic logic is_bar(input mop_kind_e k);
    return (k == MK_LDBAR) || (k == MK_STBAR) || (k == MK_FULLBAR);
  endfunction
endpackage

// File: rtl/ord_slots.sv
module ord_slots
  import ord_pkg::*;
#(
  parameter int DEPTH = 10,
  parameter int LQ_N  = 6,
  parameter int SQ_N  = 4,
  parameter int IDX_W = 4,
  parameter int LC_W  = 3,
  parameter int SC_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  mop_kind_e             req_kind,
  input  logic                  cmp_valid,
  input  logic [IDX_W-1:0]      cmp_idx,
  output logic                  accept,
  output logic [IDX_W-1:0]      tail_idx,
  output logic [IDX_W-1:0]      head_idx,
  output logic                  lq_full,
  output logic                  sq_full,
  output logic [DEPTH-1:0]      slot_valid,
  output logic [DEPTH-1:0]      slot_done,
  output mop_kind_e [DEPTH-1:0] slot_kind
);
  logic [DEPTH-1:0]      valid_q, valid_d, done_q, done_d;
  mop_kind_e [DEPTH-1:0] kind_q;
  logic [IDX_W-1:0]      head_q, head_d, tail_q, tail_d;
  logic [LC_W-1:0]       ld_cnt_q, ld_cnt_d;
  logic [SC_W-1:0]       st_cnt_q, st_cnt_d;
  logic                  need_lq, need_sq, pop;
  mop_kind_e             head_kind;

  function automatic logic [IDX_W-1:0] ring_inc(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign lq_full   = (ld_cnt_q == LC_W'(LQ_N));
  assign sq_full   = (st_cnt_q == SC_W'(SQ_N));
  assign need_lq   = takes_lq(req_kind);
  assign need_sq   = takes_sq(req_kind);
  assign accept    = req_valid && (need_lq || need_sq) &&
                     !(need_lq && lq_full) && !(need_sq && sq_full);
  assign head_kind = kind_q[head_q];
  assign pop       = valid_q[head_q] && (done_q[head_q] || is_bar(head_kind));

  always_comb begin
    valid_d = valid_q;
    done_d  = done_q;
    if (pop) begin
      valid_d[head_q] = 1'b0;
      done_d[head_q]  = 1'b0;
    end
    if (cmp_valid) done_d[cmp_idx] = 1'b1;
    if (accept) begin
      valid_d[tail_q] = 1'b1;
      done_d[tail_q]  = 1'b0;
    end
    head_d   = pop ? ring_inc(head_q) : head_q;
    tail_d   = accept ? ring_inc(tail_q) : tail_q;
    ld_cnt_d = ld_cnt_q + LC_W'(accept && need_lq) - LC_W'(pop && takes_lq(head_kind));
    st_cnt_d = st_cnt_q + SC_W'(accept && need_sq) - SC_W'(pop && takes_sq(head_kind));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= '0;
      done_q   <= '0;
      head_q   <= '0;
      tail_q   <= '0;
      ld_cnt_q <= '0;
      st_cnt_q <= '0;
    end else begin
      if (pop || accept || cmp_valid) begin
        valid_q <= valid_d;
        done_q  <= done_d;
      end
      if (pop) head_q <= head_d;
      if (accept) tail_q <= tail_d;
      if (pop || accept) begin
        ld_cnt_q <= ld_cnt_d;
        st_cnt_q <= st_cnt_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) kind_q[tail_q] <= req_kind;
  end

  assign slot_valid = valid_q;
  assign slot_done  = done_q;
  assign slot_kind  = kind_q;
  assign tail_idx   = tail_q;
  assign head_idx   = head_q;

  // R10
  cmp_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> (int'(cmp_idx) < DEPTH) && valid_q[cmp_idx] && !done_q[cmp_idx]
                  && !is_bar(kind_q[cmp_idx]));

  // R3
  budget_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_cnt_q <= LC_W'(LQ_N)) && (st_cnt_q <= SC_W'(SQ_N)));
endmodule

// File: rtl/ord_perm_scan.sv
module ord_perm_scan
  import ord_pkg::*;
#(
  parameter int DEPTH = 10,
  parameter int IDX_W = 4
) (
  input  logic [DEPTH-1:0]      slot_valid,
  input  logic [DEPTH-1:0]      slot_done,
  input  mop_kind_e [DEPTH-1:0] slot_kind,
  input  logic [IDX_W-1:0]      head_idx,
  input  logic                  no_alias,
  output logic [DEPTH-1:0]      perm
);
  always_comb begin
    logic pend_ld, pend_st, ld_fence, st_fence, ld_order_blk, live;
    int   s;
    perm         = '0;
    pend_ld      = 1'b0;
    pend_st      = 1'b0;
    ld_fence     = 1'b0;
    st_fence     = 1'b0;
    ld_order_blk = 1'b0;
    for (int r = 0; r < DEPTH; r++) begin
      s = int'(head_idx) + r;
      if (s >= DEPTH) s = s - DEPTH;
      live = slot_valid[s] && !slot_done[s];
      if (slot_valid[s]) begin
        case (slot_kind[s])
          MK_LOAD: begin
            perm[s] = live && !ld_fence && !ld_order_blk && (no_alias || !pend_st);
            if (live) pend_ld = 1'b1;
          end
          MK_STORE: begin
            perm[s] = live && !pend_ld && !pend_st && !st_fence;
            if (pend_ld) ld_order_blk = 1'b1;
            if (live) pend_st = 1'b1;
          end
          MK_LDBAR: begin
            perm[s] = (r == 0);
            if (pend_ld) ld_order_blk = 1'b1;
            ld_fence = 1'b1;
          end
          MK_STBAR: begin
            perm[s] = (r == 0);
            if (pend_ld) ld_order_blk = 1'b1;
            st_fence = 1'b1;
          end
          MK_FULLBAR: begin
            perm[s] = (r == 0);
            if (pend_ld) ld_order_blk = 1'b1;
            ld_fence = 1'b1;
            st_fence = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ord_stall_ctr.sv
module ord_stall_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic         accept,
  output logic [W-1:0] cnt
);
  logic         cnt_en;
  logic [W-1:0] cnt_q, cnt_d;

  assign cnt_en = req_valid && !accept;
  assign cnt_d  = cnt_q + W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/mem_order_queue.sv
module mem_order_queue
  import ord_pkg::*;
#(
  parameter int LQ_SIZE = 0,
  parameter int SQ_SIZE = 0,
  parameter int DEF_LQ  = 6,
  parameter int DEF_SQ  = 4,
  parameter int STALL_W = 16,
  localparam int LQ_N   = (LQ_SIZE == 0) ? DEF_LQ : LQ_SIZE,
  localparam int SQ_N   = (SQ_SIZE == 0) ? DEF_SQ : SQ_SIZE,
  localparam int DEPTH  = LQ_N + SQ_N,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int LC_W   = $clog2(LQ_N + 1),
  localparam int SC_W   = $clog2(SQ_N + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_valid,
  input  logic [2:0]         alloc_kind,
  input  logic               no_alias,
  input  logic               cmp_valid,
  input  logic [IDX_W-1:0]   cmp_idx,
  output logic               alloc_ok,
  output logic [IDX_W-1:0]   alloc_idx,
  output logic               lq_full,
  output logic               sq_full,
  output logic [DEPTH-1:0]   exec_ok,
  output logic [STALL_W-1:0] stall_cnt
);
  mop_kind_e             req_kind;
  logic [DEPTH-1:0]      slot_valid, slot_done, bar_mask, st_mask;
  mop_kind_e [DEPTH-1:0] slot_kind;
  logic [IDX_W-1:0]      head_idx;

  assign req_kind = mop_kind_e'(alloc_kind);

  ord_slots #(
    .DEPTH(DEPTH), .LQ_N(LQ_N), .SQ_N(SQ_N),
    .IDX_W(IDX_W), .LC_W(LC_W), .SC_W(SC_W)
  ) u_slots (
    .clk(clk), .rst_n(rst_n),
    .req_valid(alloc_valid), .req_kind(req_kind),
    .cmp_valid(cmp_valid), .cmp_idx(cmp_idx),
    .accept(alloc_ok), .tail_idx(alloc_idx), .head_idx(head_idx),
    .lq_full(lq_full), .sq_full(sq_full),
    .slot_valid(slot_valid), .slot_done(slot_done), .slot_kind(slot_kind)
  );

  ord_perm_scan #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_scan (
    .slot_valid(slot_valid), .slot_done(slot_done), .slot_kind(slot_kind),
    .head_idx(head_idx), .no_alias(no_alias), .perm(exec_ok)
  );

  ord_stall_ctr #(.W(STALL_W)) u_stall (
    .clk(clk), .rst_n(rst_n),
    .req_valid(alloc_valid), .accept(alloc_ok), .cnt(stall_cnt)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_mask
    assign bar_mask[g] = slot_valid[g] && is_bar(slot_kind[g]);
    assign st_mask[g]  = slot_valid[g] && (slot_kind[g] == MK_STORE);
  end

  // R4
  lq_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && lq_full && takes_lq(req_kind)) |=>
      (stall_cnt == $past(stall_cnt) + STALL_W'(1)));

  // R5
  one_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(exec_ok & st_mask) <= 1);

  // R9
  bar_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(exec_ok & bar_mask)) |=> (head_idx != $past(head_idx)));

  // R9
  bar_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(exec_ok & bar_mask) <= 1);

  // R11
  perm_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_ok & ~(slot_valid & ~slot_done)) == '0);
endmodule

// File: tb/mem_order_queue_tb.sv
`timescale 1ns/1ps
module mem_order_queue_tb;
  localparam int LQN = 6;
  localparam int SQN = 4;
  localparam int NSLOT = 10;
  localparam int IW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, alloc_valid, no_alias, cmp_valid;
  logic [2:0] alloc_kind;
  logic [IW-1:0] cmp_idx;
  logic alloc_ok, lq_full, sq_full;
  logic [IW-1:0] alloc_idx;
  logic [NSLOT-1:0] exec_ok;
  logic [15:0] stall_cnt;

  mem_order_queue u_dut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_kind(alloc_kind),
    .no_alias(no_alias), .cmp_valid(cmp_valid), .cmp_idx(cmp_idx),
    .alloc_ok(alloc_ok), .alloc_idx(alloc_idx), .lq_full(lq_full), .sq_full(sq_full),
    .exec_ok(exec_ok), .stall_cnt(stall_cnt)
  );

  typedef struct { int kind; int slot; bit done; } ent_t;
  ent_t mq[$];
  int tail_m, stall_m, ld_used, st_used, exp_ok;
  int exp_perm [NSLOT];
  int n_cmp = 0, n_bad = 0;
  bit fin = 0;

  function automatic bit uses_l(int k); return k == 0 || k == 2 || k == 4; endfunction
  function automatic bit uses_s(int k); return k == 1 || k == 3 || k == 4; endfunction

  task automatic check(bit good, string tag, string what, int act, int exp);
    n_cmp++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_eval();
    int k;
    ld_used = 0; st_used = 0;
    foreach (mq[i]) begin
      if (uses_l(mq[i].kind)) ld_used++;
      if (uses_s(mq[i].kind)) st_used++;
    end
    k = int'(alloc_kind);
    exp_ok = alloc_valid && (uses_l(k) || uses_s(k)) &&
             !(uses_l(k) && ld_used == LQN) && !(uses_s(k) && st_used == SQN);
    for (int i = 0; i < NSLOT; i++) exp_perm[i] = 0;
    for (int p = 0; p < mq.size(); p++) begin
      bit ok = 1;
      if (mq[p].kind >= 2) ok = (p == 0);
      else if (mq[p].done) ok = 0;
      else begin
        for (int q = 0; q < p; q++) begin
          int oq = mq[q].kind;
          if (mq[p].kind == 1) begin
            if ((oq <= 1 && !mq[q].done) || oq == 3 || oq == 4) ok = 0;
          end else begin
            if (oq == 2 || oq == 4) ok = 0;
            if (oq == 1 && !mq[q].done && !no_alias) ok = 0;
            if (oq == 0 && !mq[q].done)
              for (int m = q + 1; m < p; m++) if (mq[m].kind != 0) ok = 0;
          end
        end
      end
      exp_perm[mq[p].slot] = ok;
    end
  endtask

  task automatic compare_all();
    check(alloc_ok == exp_ok[0], "R2 R3 R4", "alloc_ok", int'(alloc_ok), exp_ok);
    if (exp_ok != 0) check(int'(alloc_idx) == tail_m, "R2 R10", "alloc_idx", int'(alloc_idx), tail_m);
    check(lq_full == (ld_used == LQN), "R3", "lq_full", int'(lq_full), int'(ld_used == LQN));
    check(sq_full == (st_used == SQN), "R3", "sq_full", int'(sq_full), int'(st_used == SQN));
    check(int'(stall_cnt) == stall_m, "R4", "stall_cnt", int'(stall_cnt), stall_m);
    for (int s = 0; s < NSLOT; s++) begin
      string tag = "R11";
      foreach (mq[i]) if (mq[i].slot == s)
        tag = (mq[i].kind == 0) ? "R6 R7 R8 R11" : (mq[i].kind == 1) ? "R5 R8 R11" : "R9";
      check(int'(exec_ok[s]) == exp_perm[s], tag, $sformatf("exec_ok[%0d]", s),
            int'(exec_ok[s]), exp_perm[s]);
    end
  endtask

  task automatic model_step();
    if (mq.size() > 0 && (mq[0].done || mq[0].kind >= 2)) void'(mq.pop_front());
    if (cmp_valid) foreach (mq[i]) if (mq[i].slot == int'(cmp_idx)) mq[i].done = 1;
    if (exp_ok != 0) begin
      ent_t e;
      e.kind = int'(alloc_kind); e.slot = tail_m; e.done = 0;
      mq.push_back(e);
      tail_m = (tail_m + 1) % NSLOT;
    end
    if (alloc_valid && exp_ok == 0) stall_m++;
  endtask

  task automatic cycle(bit av, int k, bit na, int rate);
    int cand[$];
    @(posedge clk); #1;
    alloc_valid = av; alloc_kind = 3'(k); no_alias = na;
    model_eval();
    foreach (mq[i]) if (mq[i].kind <= 1 && exp_perm[mq[i].slot] != 0) cand.push_back(mq[i].slot);
    if (cand.size() > 0 && int'($urandom % 100) < rate) begin
      cmp_valid = 1'b1;
      cmp_idx = IW'(cand[$urandom % cand.size()]);
    end else begin
      cmp_valid = 1'b0;
      cmp_idx = '0;
    end
    @(negedge clk);
    compare_all();
    model_step();
  endtask

  task automatic drain(bit na);
    for (int i = 0; i < 40; i++) cycle(0, 0, na, 100);
  endtask

  function automatic int rand_kind();
    int r = int'($urandom % 20);
    return r < 7 ? 0 : r < 13 ? 1 : r < 15 ? 2 : r < 17 ? 3 : r < 19 ? 4 : 5;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    rst_n = 1'b0; alloc_valid = 1'b0; alloc_kind = '0; no_alias = 1'b0;
    cmp_valid = 1'b0; cmp_idx = '0;
    mq.delete(); tail_m = 0; stall_m = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    check(exec_ok == '0, "R1", "exec_ok in reset", int'(exec_ok), 0);
    check(stall_cnt == '0 && !lq_full && !sq_full, "R1", "flags in reset", int'(stall_cnt), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 after release
    check(exec_ok == '0 && !lq_full && !sq_full && stall_cnt == '0, "R1",
          "state after reset", int'(exec_ok), 0);

    // store then load: held without no_alias (R6), freed once the mode is set
    cycle(1, 1, 0, 0); cycle(1, 0, 0, 0); cycle(0, 0, 0, 0); cycle(0, 0, 1, 0);
    drain(0);
    // fill the load budget and keep offering (R3, R4)
    for (int i = 0; i < 9; i++) cycle(1, 0, 1, 0);
    for (int i = 0; i < 6; i++) cycle(1, 1, 1, 0);
    cycle(1, 4, 1, 0); cycle(1, 5, 1, 0);
    drain(1);
    // barriers between loads and stores (R7, R8, R9)
    cycle(1, 0, 1, 0); cycle(1, 2, 1, 0); cycle(1, 0, 1, 0); cycle(1, 1, 1, 0);
    cycle(1, 3, 1, 0); cycle(1, 1, 1, 0); cycle(1, 4, 1, 0); cycle(1, 0, 1, 0);
    cycle(0, 0, 1, 0); cycle(0, 0, 0, 0);
    drain(0);
    // load, store, load with no completions (R7)
    cycle(1, 0, 1, 0); cycle(1, 1, 1, 0); cycle(1, 0, 1, 0); cycle(0, 0, 1, 0);
    drain(1);
    // random traffic in several regimes
    for (int ph = 0; ph < 6; ph++) begin
      for (int i = 0; i < 3000; i++) begin
        int ap = (ph % 3 == 0) ? 90 : (ph % 3 == 1) ? 50 : 30;
        int cr = (ph % 3 == 0) ? 20 : (ph % 3 == 1) ? 60 : 90;
        cycle(int'($urandom % 100) < ap, rand_kind(), ph[0], cr);
      end
      drain(ph[0]);
    end
    fin = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule